// File: doc/BRIEF.md
# DMA Control Register Bank

This block is the software-visible face of a DMA engine. A CPU reaches it through a 32-bit slave port that carries word, halfword and byte accesses. The block keeps the transfer descriptor: source, destination, length, and the zero-fill and burst attributes. It also keeps an enable bit, an interrupt-enable bit, an abort request and a completed-length word. When software asks for a start, the block issues a single-cycle start pulse to the engine.

The engine reports back over plain pins. It drives a live busy level and single-cycle pulses that set sticky status flags: done, address error, bus error and end state. It can also load the completed-length register. Software clears a sticky flag by writing 1 to its bit position. A registered interrupt line stays high while done and interrupt-enable are both set.

Sub-word accesses take effect only on the byte lane that holds the least-significant bits of a register. The position of that lane follows the `big_endian_i` input. Reads are combinational, so `cpu_rdata_o` is valid in the same cycle as the request. Writes take effect at the next rising clock edge. The port has no back-pressure: every request completes in one cycle.

Top module: `dma_regbank`

## Requirements
- R1: After reset, all flags, the start pulse and the interrupt are 0. Length, source, destination and completed-length read as zero.
- R2: A write to control (offset 0x08) with bit 0 set while `eng_busy_i` is low makes `eng_start_o` high for exactly the cycle after the write edge. While busy, such a write produces no pulse. Bit 1 (abort) is always loaded and reads back at bit 1. Bit 0 always reads 0.
- R3: Status (offset 0x0C) bits 1..4 are done, address-error, bus-error and end-state. An engine pulse sets a bit. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and software cannot set it. A set and a clear in the same cycle leave the bit set.
- R4: Word offsets 0x24 and above read as zero and ignore writes. Size code 3 reads as zero and ignores writes.
- R5: The word offsets are as follows. 0x00: enable, bit 0. 0x04: interrupt-enable, bit 0. 0x10: attributes, bit 0 zero-fill and bit 1 burst. 0x14: length. 0x18: source. 0x1C: destination. 0x20: completed-length. The descriptor outputs follow these registers.
- R6: Sub-word write data is taken right-justified from `cpu_wdata_i` and zero-extended to 32 bits. Sub-word reads return the register's low 8 or 16 bits, right-justified.
- R7: Size codes are 0 for byte, 1 for halfword and 2 for word. Word accesses must be at byte offset 0. In little-endian mode, byte and halfword accesses must be at byte offset 0. In big-endian mode, halfword accesses must be at offset 2 and byte accesses at offset 3. Any other access reads 0 and ignores writes.
- R8: `irq_o` goes high one cycle after done and interrupt-enable are both set. It falls one cycle after either one clears.
- R9: Status bit 0 shows `eng_busy_i` live. Software writes do not affect it.
- R10: A pulse on `eng_cnt_we_i` loads `eng_cnt_i` into completed-length and takes priority over a software write in the same cycle. A software write to completed-length also loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian_i | input | 1 | Selects the big-endian sub-word lane rule |
| cpu_req_i | input | 1 | Access request |
| cpu_we_i | input | 1 | 1 for a write, 0 for a read |
| cpu_addr_i | input | ADDR_W | Byte offset |
| cpu_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata_i | input | DATA_W | Write data, right-justified |
| cpu_rdata_o | output | DATA_W | Read data, right-justified |
| eng_enable_o | output | 1 | Engine enable |
| eng_start_o | output | 1 | Single-cycle start pulse |
| eng_abort_o | output | 1 | Abort request level |
| eng_zero_o | output | 1 | Zero-fill attribute |
| eng_burst_o | output | 1 | Burst attribute |
| eng_len_o | output | DATA_W | Transfer length |
| eng_src_o | output | DATA_W | Source address |
| eng_dst_o | output | DATA_W | Destination address |
| eng_busy_i | input | 1 | Engine busy level |
| eng_done_i | input | 1 | Pulse that sets done |
| eng_addr_err_i | input | 1 | Pulse that sets address-error |
| eng_bus_err_i | input | 1 | Pulse that sets bus-error |
| eng_end_i | input | 1 | Pulse that sets end-state |
| eng_cnt_we_i | input | 1 | Load strobe for completed-length |
| eng_cnt_i | input | DATA_W | Completed-length value from the engine |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong lane decision or a dropped zero-extension shows up in the read-back of the targeted register on the very next access. It also shows directly on the descriptor outputs one cycle after the write. A corrupted sticky flag reaches `cpu_rdata_o` combinationally, and it reaches `irq_o` one cycle later. A start request that is not blocked during busy shows as a stray `eng_start_o` pulse in the cycle that follows the write.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int unsigned IDX_ENABLE  = 0;
  localparam int unsigned IDX_IEN     = 1;
  localparam int unsigned IDX_CTRL    = 2;
  localparam int unsigned IDX_STATUS  = 3;
  localparam int unsigned IDX_ATTR    = 4;
  localparam int unsigned IDX_LEN     = 5;
  localparam int unsigned IDX_SRC     = 6;
  localparam int unsigned IDX_DST     = 7;
  localparam int unsigned IDX_DONELEN = 8;
  localparam int unsigned NUM_FLAGS   = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/dmarb_lane.sv
module dmarb_lane import dmarb_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              big_endian_i,
  input  logic [1:0]        lane_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] wext_o,
  output logic [DATA_W-1:0] rmask_o
);
  always_comb begin
    hit_o   = 1'b0;
    wext_o  = '0;
    rmask_o = '0;
    case (acc_size_e'(size_i))
      SZ_BYTE: begin
        hit_o   = (lane_i == (big_endian_i ? 2'd3 : 2'd0));
        wext_o  = {{(DATA_W-8){1'b0}}, wdata_i[7:0]};
        rmask_o = {{(DATA_W-8){1'b0}}, 8'hFF};
      end
      SZ_HALF: begin
        hit_o   = (lane_i == (big_endian_i ? 2'd2 : 2'd0));
        wext_o  = {{(DATA_W-16){1'b0}}, wdata_i[15:0]};
        rmask_o = {{(DATA_W-16){1'b0}}, 16'hFFFF};
      end
      SZ_WORD: begin
        hit_o   = (lane_i == 2'd0);
        wext_o  = wdata_i;
        rmask_o = '1;
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dmarb_flags.sv
module dmarb_flags #(
  parameter int unsigned NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flags_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1;
      else if (clr_i[g]) f_q <= 1'b0;
    end
    assign flags_o[g] = f_q;
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank import dmarb_pkg::*; #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]        cpu_size_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              eng_enable_o,
  output logic              eng_start_o,
  output logic              eng_abort_o,
  output logic              eng_zero_o,
  output logic              eng_burst_o,
  output logic [DATA_W-1:0] eng_len_o,
  output logic [DATA_W-1:0] eng_src_o,
  output logic [DATA_W-1:0] eng_dst_o,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic              eng_addr_err_i,
  input  logic              eng_bus_err_i,
  input  logic              eng_end_i,
  input  logic              eng_cnt_we_i,
  input  logic [DATA_W-1:0] eng_cnt_i,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned NF    = NUM_FLAGS;
  localparam logic [IDX_W-1:0] A_EN   = IDX_W'(IDX_ENABLE);
  localparam logic [IDX_W-1:0] A_IEN  = IDX_W'(IDX_IEN);
  localparam logic [IDX_W-1:0] A_CTRL = IDX_W'(IDX_CTRL);
  localparam logic [IDX_W-1:0] A_STAT = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] A_ATTR = IDX_W'(IDX_ATTR);
  localparam logic [IDX_W-1:0] A_LEN  = IDX_W'(IDX_LEN);
  localparam logic [IDX_W-1:0] A_SRC  = IDX_W'(IDX_SRC);
  localparam logic [IDX_W-1:0] A_DST  = IDX_W'(IDX_DST);
  localparam logic [IDX_W-1:0] A_CNT  = IDX_W'(IDX_DONELEN);

  logic [IDX_W-1:0]  idx;
  logic              lane_hit, sw_wr;
  logic [DATA_W-1:0] wext, rmask, rword;
  logic              en_q, ien_q, abort_q, zero_q, burst_q, start_q, irq_q;
  logic [DATA_W-1:0] len_q, src_q, dst_q, cnt_q;
  logic [NF-1:0]     flags_q, flag_set, flag_clr;

  assign idx = cpu_addr_i[ADDR_W-1:2];

  dmarb_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .big_endian_i (big_endian_i),
    .lane_i       (cpu_addr_i[1:0]),
    .size_i       (cpu_size_i),
    .wdata_i      (cpu_wdata_i),
    .hit_o        (lane_hit),
    .wext_o       (wext),
    .rmask_o      (rmask)
  );

  assign sw_wr    = cpu_req_i && cpu_we_i && lane_hit;
  assign flag_set = {eng_end_i, eng_bus_err_i, eng_addr_err_i, eng_done_i};
  assign flag_clr = (sw_wr && idx == A_STAT) ? wext[NF:1] : '0;

  dmarb_flags #(.NF(NF)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flags_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; ien_q <= 1'b0; abort_q <= 1'b0;
      zero_q <= 1'b0; burst_q <= 1'b0; start_q <= 1'b0; irq_q <= 1'b0;
      len_q <= '0; src_q <= '0; dst_q <= '0; cnt_q <= '0;
    end else begin
      if (sw_wr) begin
        case (idx)
          A_EN:   en_q    <= wext[0];
          A_IEN:  ien_q   <= wext[0];
          A_CTRL: abort_q <= wext[1];
          A_ATTR: begin zero_q <= wext[0]; burst_q <= wext[1]; end
          A_LEN:  len_q   <= wext;
          A_SRC:  src_q   <= wext;
          A_DST:  dst_q   <= wext;
          A_CNT:  cnt_q   <= wext;
          default: ;
        endcase
      end
      if (eng_cnt_we_i) cnt_q <= eng_cnt_i;
      start_q <= sw_wr && (idx == A_CTRL) && wext[0] && !eng_busy_i;
      irq_q   <= flags_q[0] && ien_q;
    end
  end

  always_comb begin
    rword = '0;
    case (idx)
      A_EN:   rword[0]    = en_q;
      A_IEN:  rword[0]    = ien_q;
      A_CTRL: rword[1]    = abort_q;
      A_STAT: rword[NF:0] = {flags_q, eng_busy_i};
      A_ATTR: rword[1:0]  = {burst_q, zero_q};
      A_LEN:  rword       = len_q;
      A_SRC:  rword       = src_q;
      A_DST:  rword       = dst_q;
      A_CNT:  rword       = cnt_q;
      default: rword      = '0;
    endcase
    cpu_rdata_o = (cpu_req_i && lane_hit) ? (rword & rmask) : '0;
  end

  assign eng_enable_o = en_q;
  assign eng_start_o  = start_q;
  assign eng_abort_o  = abort_q;
  assign eng_zero_o   = zero_q;
  assign eng_burst_o  = burst_q;
  assign eng_len_o    = len_q;
  assign eng_src_o    = src_q;
  assign eng_dst_o    = dst_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/dmarb_chk.sv
module dmarb_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              eng_busy_i,
  input logic              eng_done_i,
  input logic              eng_start_o,
  input logic              irq_o,
  input logic              ien_q,
  input logic              done_q,
  input logic [DATA_W-1:0] len_q
);
  // R2
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> $past(cpu_req_i && cpu_we_i && !eng_busy_i));
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done_i |=> done_q);
  // R3
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !eng_done_i) |=> !done_q);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(ien_q));
  // R4
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_i && cpu_we_i && cpu_addr_i[ADDR_W-1:2] > 8) |=> $stable(len_q));
endmodule

bind dma_regbank dmarb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .eng_busy_i  (eng_busy_i),
  .eng_done_i  (eng_done_i),
  .eng_start_o (eng_start_o),
  .irq_o       (irq_o),
  .ien_q       (ien_q),
  .done_q      (flags_q[0]),
  .len_q       (len_q)
);

// File: tb/dma_regbank_tb.sv
module dma_regbank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // {we, size, addr, wdata, expected read}
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 2'd2, 6'h14, 32'h12345678, 32'h0},
    {1'b0, 2'd2, 6'h14, 32'h0,        32'h12345678},
    {1'b1, 2'd0, 6'h14, 32'hFFFFFFAB, 32'h0},
    {1'b0, 2'd2, 6'h14, 32'h0,        32'h000000AB},
    {1'b1, 2'd1, 6'h16, 32'h00005555, 32'h0},
    {1'b0, 2'd2, 6'h14, 32'h0,        32'h000000AB},
    {1'b0, 2'd1, 6'h14, 32'h0,        32'h000000AB},
    {1'b0, 2'd0, 6'h15, 32'h0,        32'h0},
    {1'b1, 2'd2, 6'h18, 32'hCAFEF00D, 32'h0},
    {1'b0, 2'd1, 6'h18, 32'h0,        32'h0000F00D},
    {1'b1, 2'd2, 6'h28, 32'hFFFFFFFF, 32'h0},
    {1'b0, 2'd2, 6'h28, 32'h0,        32'h0},
    {1'b1, 2'd2, 6'h10, 32'h00000003, 32'h0},
    {1'b0, 2'd2, 6'h10, 32'h0,        32'h00000003},
    {1'b0, 2'd3, 6'h14, 32'h0,        32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0, be = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [1:0] size = 2'd2;
  logic [31:0] wdata = '0, rdata, len, src, dst, cnt = '0;
  logic en, start, abort, zero, burst, irq;
  logic busy = 1'b0, done = 1'b0, aerr = 1'b0, berr = 1'b0, endst = 1'b0, cnt_we = 1'b0;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .big_endian_i(be),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_addr_i(addr), .cpu_size_i(size),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .eng_enable_o(en), .eng_start_o(start), .eng_abort_o(abort),
    .eng_zero_o(zero), .eng_burst_o(burst),
    .eng_len_o(len), .eng_src_o(src), .eng_dst_o(dst),
    .eng_busy_i(busy), .eng_done_i(done), .eng_addr_err_i(aerr),
    .eng_bus_err_i(berr), .eng_end_i(endst),
    .eng_cnt_we_i(cnt_we), .eng_cnt_i(cnt), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [1:0] s, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; size = s; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [1:0] s,
                    input logic [31:0] exp);
    req = 1'b1; we = 1'b0; addr = a; size = s;
    #1;
    chk(tag, rdata, exp);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    // R1 reset state
    rd("R1 len", 6'h14, 2'd2, 32'h0);
    rd("R1 src", 6'h18, 2'd2, 32'h0);
    rd("R1 dst", 6'h1C, 2'd2, 32'h0);
    rd("R1 donelen", 6'h20, 2'd2, 32'h0);
    rd("R1 status", 6'h0C, 2'd2, 32'h0);
    chk("R1 irq/start", {30'h0, irq, start}, 32'h0);

    // Table: R5 map, R6 zero-extension, R7 lanes, R4 unmapped and bad size
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) wr(VEC[i][69:64], VEC[i][71:70], VEC[i][63:32]);
      else rd($sformatf("R5/R6/R7/R4 row %0d", i), VEC[i][69:64], VEC[i][71:70], VEC[i][31:0]);
    end
    chk("R5 eng_len_o", len, 32'h000000AB);
    chk("R5 eng_src_o", src, 32'hCAFEF00D);
    chk("R5 zero/burst", {30'h0, burst, zero}, 32'h3);
    wr(6'h1C, 2'd2, 32'h00000400);
    chk("R5 eng_dst_o", dst, 32'h00000400);
    wr(6'h00, 2'd2, 32'h1);
    chk("R5 enable", {31'h0, en}, 32'h1);

    // R7 big-endian lanes, R6 zero extension
    be = 1'b1;
    wr(6'h16, 2'd1, 32'hFFFF0077);
    rd("R6 be half zext", 6'h14, 2'd2, 32'h00000077);
    rd("R7 be half read", 6'h16, 2'd1, 32'h00000077);
    rd("R7 be byte read", 6'h17, 2'd0, 32'h00000077);
    wr(6'h14, 2'd0, 32'h00000011);
    rd("R7 be byte off0 ignored", 6'h14, 2'd2, 32'h00000077);
    rd("R7 be half off0 reads 0", 6'h14, 2'd1, 32'h0);
    be = 1'b0;

    // R2 start and abort
    wr(6'h08, 2'd2, 32'h1);
    chk("R2 start pulse", {31'h0, start}, 32'h1);
    @(negedge clk);
    chk("R2 start one cycle", {31'h0, start}, 32'h0);
    busy = 1'b1;
    wr(6'h08, 2'd2, 32'h3);
    chk("R2 start ignored busy", {31'h0, start}, 32'h0);
    chk("R2 abort loaded busy", {31'h0, abort}, 32'h1);
    rd("R2 ctrl readback", 6'h08, 2'd2, 32'h2);
    // R9 busy is live and read-only
    rd("R9 busy visible", 6'h0C, 2'd2, 32'h1);
    busy = 1'b0;
    wr(6'h0C, 2'd2, 32'h1F);
    rd("R9 busy not writable", 6'h0C, 2'd2, 32'h0);

    // R3 sticky flags, R8 interrupt timing
    wr(6'h04, 2'd2, 32'h1);
    done = 1'b1; aerr = 1'b1;
    @(negedge clk);
    done = 1'b0; aerr = 1'b0;
    chk("R8 irq not yet", {31'h0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq high", {31'h0, irq}, 32'h1);
    rd("R3 flags set", 6'h0C, 2'd2, 32'h6);
    wr(6'h0C, 2'd2, 32'h0);
    rd("R3 write 0 keeps", 6'h0C, 2'd2, 32'h6);
    wr(6'h0C, 2'd2, 32'h2);
    rd("R3 w1c done", 6'h0C, 2'd2, 32'h4);
    chk("R8 irq lags clear", {31'h0, irq}, 32'h0);
    // set wins over clear in same cycle
    req = 1'b1; we = 1'b1; addr = 6'h0C; size = 2'd2; wdata = 32'h10; endst = 1'b1;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0; endst = 1'b0;
    rd("R3 set wins", 6'h0C, 2'd2, 32'h14);

    // R10 completed-length
    cnt = 32'd7; cnt_we = 1'b1;
    @(negedge clk);
    cnt_we = 1'b0;
    rd("R10 engine load", 6'h20, 2'd2, 32'd7);
    wr(6'h20, 2'd2, 32'd9);
    rd("R10 sw load", 6'h20, 2'd2, 32'd9);
    cnt = 32'd5; cnt_we = 1'b1;
    wr(6'h20, 2'd2, 32'd11);
    cnt_we = 1'b0;
    rd("R10 engine priority", 6'h20, 2'd2, 32'd5);

    // R1 reset again clears everything
    do_reset();
    rd("R1 len after reset", 6'h14, 2'd2, 32'h0);
    rd("R1 status after reset", 6'h0C, 2'd2, 32'h0);
    chk("R1 outputs after reset", {28'h0, en, abort, zero, burst}, 32'h0);

    summary();
  end
endmodule